// File: doc/BRIEF.md
# Dual-LFSR Complex Scrambling Code Generator

The block produces a long complex scrambling code for a spread-spectrum link, one chip per accepted handshake. Two 25-stage binary shift registers step together: the first is seeded from a code-number input, the second always restarts from all ones. Two binary streams come from XOR taps across both registers. A first stream is taken from the lowest stage of each register. A second stream comes from a six-tap mask over both registers, which gives a shifted copy of the code. The two streams are combined into an I chip and a Q chip.

A load pulse starts a code period of 2400 groups of 16 chips (38400 chips). The last chip of a period is flagged. After the last chip, a parameter selects one of two outcomes: the generator stops, or it restarts from the stored seed. Chips leave on a valid/ready stream. While `chip_valid_o` is high and `chip_ready_i` is low, the current chip is held unchanged and nothing advances, so the consumer may stall for any length of time. `en_i` gates the stream: while it is low, valid is low and all state freezes.

Top module: `scr_gold_gen`

## Requirements
- R1: After reset, `chip_valid_o` and `frame_last_o` are low, and they stay low until a load pulse.
- R2: A load pulse puts `seed_i` into register X and 25 ones into register Y. Chip 0 of the new code is presented in the cycle after the pulse.
- R3: On each accepted chip, both registers shift toward bit 0. The new top bit of X is x[3]^x[0]. The new top bit of Y is y[3]^y[2]^y[1]^y[0].
- R4: `chip_i_o` equals x[0]^y[0] for the current state. Bit value 0 stands for +1 and bit value 1 stands for -1.
- R5: Let c2 = x[4]^x[7]^x[18]^y[4]^y[6]^y[17]. On an even chip index, `chip_q_o` = `chip_i_o`^c2. On an odd chip index, `chip_q_o` = `chip_i_o`^c2h^1, where c2h is the c2 captured on the preceding even chip.
- R6: While `en_i` is low, `chip_valid_o` is low. The registers, the chip index and c2h do not change.
- R7: While `chip_valid_o` is high and `chip_ready_i` is low, the next cycle shows the same chip and nothing advances.
- R8: A load pulse takes priority over a handshake in the same cycle. The chip index restarts at 0.
- R9: `frame_last_o` is high exactly when a valid chip with index 38399 is presented.
- R10: After chip 38399 is accepted, the stop variant (`AUTO_RELOAD`=0) holds valid low until the next load. The reload variant presents chip 0 of the stored seed next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start pulse; loads seed and restarts the code |
| seed_i | input | 25 | Initial value for register X |
| en_i | input | 1 | Stream enable; low freezes the generator |
| chip_ready_i | input | 1 | Consumer accepts the current chip |
| chip_valid_o | output | 1 | A chip is presented |
| chip_i_o | output | 1 | In-phase chip bit (0 = +1, 1 = -1) |
| chip_q_o | output | 1 | Quadrature chip bit (0 = +1, 1 = -1) |
| frame_last_o | output | 1 | Presented chip is the last of the period |

## Verification
The assertions check the following on every cycle:
- valid is low while disabled and right after reset;
- a stalled chip stays stable;
- a load is followed by chip 0 of the new seed, with the expected I bit;
- the last-chip flag agrees with a count of accepted chips that the checker keeps itself.

The full I/Q sequence can only be shown by the bench's scenarios. The bench compares it against an independent model of both registers for several seeds. The scenarios also cover:
- freezing and resuming around enable gaps and stalls;
- a reload in the middle of a stream;
- the behaviour at the end of a period in both the stop and the reload variant.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int REG_W = 25;
  typedef logic [REG_W-1:0] scr_state_t;

  // Feedback masks (new top bit = parity of masked state)
  localparam scr_state_t X_FB_MASK = 25'h000_0009; // bits 3,0
  localparam scr_state_t Y_FB_MASK = 25'h000_000F; // bits 3,2,1,0

  // Second-stream tap masks
  localparam scr_state_t X_C2_MASK = 25'h004_0090; // bits 18,7,4
  localparam scr_state_t Y_C2_MASK = 25'h002_0050; // bits 17,6,4

  localparam scr_state_t Y_SEED = {REG_W{1'b1}};

  function automatic logic parity_of(input scr_state_t v, input scr_state_t m);
    return ^(v & m);
  endfunction
endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr
  import scr_pkg::*;
#(
  parameter scr_state_t FB_MASK   = X_FB_MASK,
  parameter scr_state_t RESET_VAL = '0
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       load_i,
  input  scr_state_t load_val_i,
  input  logic       step_i,
  output scr_state_t state_o
);
  scr_state_t state_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       state_q <= RESET_VAL;
    else if (load_i) state_q <= load_val_i;
    else if (step_i) state_q <= {parity_of(state_q, FB_MASK), state_q[REG_W-1:1]};
  end

  assign state_o = state_q;
endmodule

// File: rtl/scr_chip_ctr.sv
module scr_chip_ctr #(
  parameter int FRAME_LEN = 38400,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o,
  output logic          odd_o
);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_LEN - 1);
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) idx_q <= '0;
    else if (step_i)      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);
  assign odd_o  = idx_q[0];
endmodule

// File: rtl/scr_iq_map.sv
module scr_iq_map
  import scr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic       odd_i,
  input  scr_state_t x_i,
  input  scr_state_t y_i,
  output logic       chip_i_o,
  output logic       chip_q_o
);
  logic c1, c2, c2_hold_q;

  assign c1 = x_i[0] ^ y_i[0];
  assign c2 = parity_of(x_i, X_C2_MASK) ^ parity_of(y_i, Y_C2_MASK);

  // c2 captured on even chips, reused on the odd chip that follows
  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i)     c2_hold_q <= 1'b0;
    else if (step_i && !odd_i) c2_hold_q <= c2;
  end

  assign chip_i_o = c1;
  assign chip_q_o = odd_i ? (c1 ^ c2_hold_q ^ 1'b1) : (c1 ^ c2);
endmodule

// File: rtl/scr_gold_gen.sv
module scr_gold_gen
  import scr_pkg::*;
#(
  parameter int GROUPS          = 2400,
  parameter int CHIPS_PER_GROUP = 16,
  parameter bit AUTO_RELOAD     = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [REG_W-1:0] seed_i,
  input  logic             en_i,
  input  logic             chip_ready_i,
  output logic             chip_valid_o,
  output logic             chip_i_o,
  output logic             chip_q_o,
  output logic             frame_last_o
);
  localparam int FRAME_LEN = GROUPS * CHIPS_PER_GROUP;
  localparam int CW        = $clog2(FRAME_LEN);

  scr_state_t    seed_q, x_state, y_state, x_load_val;
  logic          running_q, accept, wrap, restart;
  logic          last, odd;
  logic [CW-1:0] idx;

  assign chip_valid_o = running_q & en_i;
  assign accept       = chip_valid_o & chip_ready_i & ~load_i;
  assign wrap         = accept & last;
  assign restart      = load_i | (wrap & AUTO_RELOAD);
  assign x_load_val   = load_i ? seed_i : seed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seed_q    <= '0;
      running_q <= 1'b0;
    end else begin
      if (load_i) seed_q <= seed_i;
      if (load_i)                    running_q <= 1'b1;
      else if (wrap && !AUTO_RELOAD) running_q <= 1'b0;
    end
  end

  scr_lfsr #(.FB_MASK(X_FB_MASK), .RESET_VAL('0)) u_x (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(restart), .load_val_i(x_load_val),
    .step_i(accept), .state_o(x_state));

  scr_lfsr #(.FB_MASK(Y_FB_MASK), .RESET_VAL(Y_SEED)) u_y (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(restart), .load_val_i(Y_SEED),
    .step_i(accept), .state_o(y_state));

  scr_chip_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
    .clk_i(clk_i), .rst_i(rst_i), .clear_i(load_i), .step_i(accept),
    .idx_o(idx), .last_o(last), .odd_o(odd));

  scr_iq_map u_map (
    .clk_i(clk_i), .rst_i(rst_i), .clear_i(restart), .step_i(accept),
    .odd_i(odd), .x_i(x_state), .y_i(y_state),
    .chip_i_o(chip_i_o), .chip_q_o(chip_q_o));

  assign frame_last_o = chip_valid_o & last;

  logic unused_idx;
  assign unused_idx = ^idx;
endmodule

// File: rtl/scr_gold_gen_checker.sv
module scr_gold_gen_checker #(
  parameter int FRAME_LEN = 38400,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input logic        clk_i,
  input logic        rst_i,
  input logic        load_i,
  input logic [24:0] seed_i,
  input logic        en_i,
  input logic        chip_ready_i,
  input logic        chip_valid_o,
  input logic        chip_i_o,
  input logic        chip_q_o,
  input logic        frame_last_o
);
  logic [CW-1:0] seen_q;
  logic          hs;
  assign hs = chip_valid_o & chip_ready_i & ~load_i;

  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) seen_q <= '0;
    else if (hs)         seen_q <= (seen_q == CW'(FRAME_LEN - 1)) ? '0 : seen_q + 1'b1;
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> !chip_valid_o);

  assert_first_chip_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (chip_i_o == ~$past(seed_i[0])));

  assert_disabled_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |-> !chip_valid_o);

  assert_stall_stable_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (chip_valid_o && !chip_ready_i && !load_i) |=>
      (!chip_valid_o || ($stable(chip_i_o) && $stable(chip_q_o))));

  assert_load_starts_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (!en_i || chip_valid_o));

  assert_last_flag_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_last_o == (chip_valid_o && seen_q == CW'(FRAME_LEN - 1)));
endmodule

bind scr_gold_gen scr_gold_gen_checker #(.FRAME_LEN(GROUPS * CHIPS_PER_GROUP)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i), .seed_i(seed_i), .en_i(en_i),
  .chip_ready_i(chip_ready_i), .chip_valid_o(chip_valid_o), .chip_i_o(chip_i_o),
  .chip_q_o(chip_q_o), .frame_last_o(frame_last_o));

// File: tb/scr_gold_gen_bench.sv
`timescale 1ns/1ps
module scr_gold_gen_bench;
  localparam int FRAME = 38400;

  logic clk = 1'b0;
  logic rst = 1'b1, load = 1'b0, en = 1'b0, rdy = 1'b0;
  logic [24:0] seed = '0;
  logic v, ci, cq, fl;
  logic rv, rci, rcq, rfl;
  int   n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  scr_gold_gen u_scr_gold_gen (
    .clk_i(clk), .rst_i(rst), .load_i(load), .seed_i(seed), .en_i(en),
    .chip_ready_i(rdy), .chip_valid_o(v), .chip_i_o(ci), .chip_q_o(cq),
    .frame_last_o(fl));

  scr_gold_gen #(.AUTO_RELOAD(1'b1)) u_scr_gold_gen_reload (
    .clk_i(clk), .rst_i(rst), .load_i(load), .seed_i(seed), .en_i(en),
    .chip_ready_i(rdy), .chip_valid_o(rv), .chip_i_o(rci), .chip_q_o(rcq),
    .frame_last_o(rfl));

  // Reference model state
  logic [24:0] mx, my;
  int          midx;
  logic        mhold;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic m_c2();
    return mx[4]^mx[7]^mx[18]^my[4]^my[6]^my[17];
  endfunction
  function automatic logic m_i();
    return mx[0]^my[0];
  endfunction
  function automatic logic m_q();
    return (midx % 2 == 0) ? (m_i() ^ m_c2()) : (m_i() ^ mhold ^ 1'b1);
  endfunction

  task automatic m_load(input logic [24:0] s);
    mx = s; my = '1; midx = 0; mhold = 1'b0;
  endtask
  task automatic m_step();
    if (midx % 2 == 0) mhold = m_c2();
    mx = {mx[3]^mx[0], mx[24:1]};
    my = {my[3]^my[2]^my[1]^my[0], my[24:1]};
    midx = (midx == FRAME-1) ? 0 : midx + 1;
  endtask

  // called at a negedge; outputs show chip 0 at the following negedge
  task automatic do_load(input logic [24:0] s);
    load = 1'b1; seed = s;
    @(negedge clk);
    load = 1'b0;
    m_load(s);
  endtask

  // accept n chips, comparing I/Q against the model; one check per run
  task automatic run_chips(input int n, input string req);
    int bad = 0; int a = 0; int e = 0;
    for (int k = 0; k < n; k++) begin
      en = 1'b1; rdy = 1'b1;
      #1;
      if (bad == 0 && (v !== 1'b1 || ci !== m_i() || cq !== m_q())) begin
        bad = 1; a = {v, ci, cq}; e = {1'b1, m_i(), m_q()};
      end
      @(negedge clk);
      m_step();
    end
    check(bad == 0, req, "chip sequence {valid,i,q}", a, e);
  endtask

  task automatic t_reset();
    #1;
    check(v == 1'b0 && fl == 1'b0, "R1", "outputs after reset", {v, fl}, 0);
    en = 1'b1; rdy = 1'b1;
    @(negedge clk); #1;
    check(v == 1'b0, "R1", "valid before any load", v, 0);
    @(negedge clk);
  endtask

  task automatic t_seed_one();
    do_load(25'h0000001);
    #1;
    check(ci == 1'b0, "R2", "chip0 I for seed 1", ci, 0);
    check(cq == 1'b1, "R5", "chip0 Q for seed 1", cq, 1);
    run_chips(200, "R3 R4 R5 seed 1");
  endtask

  task automatic t_more_seeds();
    do_load(25'h1A5C3E7); run_chips(300, "R3 R5 seed 1A5C3E7");
    do_load(25'h0F0F0F0); run_chips(300, "R4 R5 seed 0F0F0F0");
    do_load(25'h1FFFFFF); run_chips(300, "R3 R4 seed all ones");
  endtask

  task automatic t_enable_gap();
    logic pi, pq;
    do_load(25'h0123456);
    run_chips(5, "R6 pre-gap");          // leaves an odd index pending
    en = 1'b0;
    #1;
    check(v == 1'b0, "R6", "valid with enable low", v, 0);
    for (int k = 0; k < 4; k++) @(negedge clk);
    #1;
    check(v == 1'b0, "R6", "valid still low", v, 0);
    run_chips(40, "R6 resume after gap");
  endtask

  task automatic t_stall();
    logic si, sq;
    do_load(25'h00ABCDE);
    run_chips(6, "R7 pre-stall");
    en = 1'b1; rdy = 1'b0;
    #1; si = ci; sq = cq;
    for (int k = 0; k < 3; k++) @(negedge clk);
    #1;
    check(v == 1'b1 && ci == si && cq == sq, "R7", "stalled chip held",
          {v, ci, cq}, {1'b1, si, sq});
    check(ci == m_i() && cq == m_q(), "R7", "no advance while stalled",
          {ci, cq}, {m_i(), m_q()});
    run_chips(40, "R7 resume after stall");
  endtask

  task automatic t_load_priority();
    do_load(25'h1357913);
    run_chips(7, "R8 pre-reload");
    en = 1'b1; rdy = 1'b1;             // handshake offered in the load cycle
    do_load(25'h0246802);
    run_chips(60, "R8 restart from chip 0");
  endtask

  task automatic t_frame_end();
    int bad = 0; int at = -1;
    logic [24:0] s = 25'h0C0FFEE & 25'h1FFFFFF;
    do_load(s);
    for (int k = 0; k < FRAME; k++) begin
      en = 1'b1; rdy = 1'b1;
      #1;
      if (fl !== (k == FRAME-1) && bad == 0) begin bad = 1; at = k; end
      if ((v !== 1'b1 || ci !== m_i() || cq !== m_q()) && bad == 0) begin
        bad = 2; at = k;
      end
      @(negedge clk);
      m_step();
    end
    check(bad == 0, "R9", "last flag / sequence over full period", at, -1);
    #1;
    check(v == 1'b0 && fl == 1'b0, "R10", "stop variant idle after period",
          {v, fl}, 0);
    m_load(s);
    check(rv == 1'b1 && rci == m_i() && rcq == m_q() && rfl == 1'b0, "R10",
          "reload variant restarts", {rv, rci, rcq, rfl},
          {1'b1, m_i(), m_q(), 1'b0});
    @(negedge clk); #1;
    check(v == 1'b0, "R10", "stop variant stays idle", v, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_seed_one();
    t_more_seeds();
    t_enable_gap();
    t_stall();
    t_load_priority();
    t_frame_end();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule